// File: doc/BRIEF.md
# PCI Interrupt Steering Unit

This unit maps a set of shared board interrupt sources onto a 16-line ISA interrupt request vector. The sources are the four active-low PCI interrupt pins (A to D), one active-low motherboard interrupt line and an IDE interrupt. The IDE interrupt is formed from two channel requests that share one routing target. Each source has its own byte-wide routing register. That register holds a 4-bit IRQ number and a control bit. Software programs the registers through a small synchronous byte write port with a combinational read path.

The control bit has opposite sense for the two kinds of source. For the PCI pins and the motherboard line, setting bit 7 switches the route off. For the IDE source, setting bit 7 switches the route on. Requests that land on the same IRQ line are ORed together. IRQ numbers 0, 2, 8 and 13 are reserved, and a source routed to one of them drives no output. The output vector is a pure function of the current registers and the source inputs, so a request reaches `irq_o` in the same cycle.

Register addresses: 0 to 3 hold the routes for PCI pins A to D, 4 holds the motherboard route and 5 holds the IDE route. Addresses 6 and 7 are unmapped.

Top module: `irq_steer_top`

## Requirements
- R1: After reset every routing register reads 0x80, and `irq_o` is all zero whatever the source inputs are.
- R2: A write keeps only the bits of mask 0x8F (bit 7 and bits 3:0), and bits 6:4 always read 0. A read returns the addressed register in the same cycle.
- R3: For PCI pin n (register n, n = 0..3), with bit 7 clear and `pci_int_ni[n]` low, the output bit given by bits 3:0 is set. With bit 7 set, or with the pin high, that route drives nothing.
- R4: The motherboard route (register 4) follows the same rule with `mb_int_ni`: bit 7 clear enables the route, the IRQ number is in bits 3:0, and the line is active low.
- R5: The IDE route (register 5) is active only when bit 7 is set. It then drives the IRQ given by bits 3:0 while either bit of `ide_int_i` (active high) is 1.
- R6: Output bits 0, 2, 8 and 13 are never driven, even when an active source is routed to one of them.
- R7: Several active sources routed to one IRQ number are ORed, so the line stays high while any one of them requests.
- R8: `irq_o` follows the source inputs with no clock edge in between. A new routing value takes effect at the clock edge that writes it, and not before.
- R9: Writes to the unmapped addresses 6 and 7 change no register and no output. Reads from those addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| pci_int_ni | input | 4 | PCI interrupt pins A to D, active low |
| mb_int_ni | input | 1 | Motherboard interrupt line, active low |
| ide_int_i | input | 2 | IDE channel interrupts, active high |
| irq_o | output | 16 | Steered ISA IRQ vector |

## Verification
The bench builds the unit with its default parameters: four PCI pins and the reserved mask covering IRQ 0, 2, 8 and 13. With these values the 3-bit address space holds all six routing registers and two unmapped addresses, so R9 can be tested at the ports. Each of the four reserved numbers is tried as a route target. The bench also sets up IRQ sharing between two PCI pins and the motherboard line. It covers both control-bit senses, checking the IDE route as enabled on a reserved IRQ at reset and then moved to a usable line.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int IRQ_W   = 16;
  localparam int NUM_W   = $clog2(IRQ_W);
  localparam int CTL_BIT = 7;
  localparam logic [7:0] RT_MASK = 8'h8F;
  localparam logic [7:0] RT_RST  = 8'h80;
  typedef logic [7:0] route_t;
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_steer_pkg::*;
#(
  parameter int NSRC = 6,
  parameter int AW   = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o,
  output route_t [NSRC-1:0]    route_o
);
  route_t [NSRC-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSRC; i++) q[i] <= RT_RST;
    end else if (wr_en_i) begin
      for (int i = 0; i < NSRC; i++)
        if (int'(addr_i) == i) q[i] <= wdata_i & RT_MASK;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NSRC; i++)
      if (int'(addr_i) == i) rdata_o = q[i];
  end

  assign route_o = q;
endmodule

// File: rtl/irq_route_dec.sv
module irq_route_dec
  import irq_steer_pkg::*;
#(
  parameter logic [IRQ_W-1:0] RSVD_MASK = 16'h2105
) (
  input  logic             en_i,
  input  logic             req_i,
  input  logic [NUM_W-1:0] num_i,
  output logic [IRQ_W-1:0] vec_o
);
  logic [IRQ_W-1:0] onehot;

  always_comb begin
    onehot = '0;
    onehot[num_i] = 1'b1;
    vec_o = (en_i && req_i) ? (onehot & ~RSVD_MASK) : '0;
  end
endmodule

// File: rtl/irq_merge.sv
module irq_merge
  import irq_steer_pkg::*;
#(
  parameter int NSRC = 6
) (
  input  logic [NSRC-1:0][IRQ_W-1:0] vec_i,
  output logic [IRQ_W-1:0]           irq_o
);
  always_comb begin
    irq_o = '0;
    for (int i = 0; i < NSRC; i++) irq_o = irq_o | vec_i[i];
  end
endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top
  import irq_steer_pkg::*;
#(
  parameter int               NUM_PCI   = 4,
  parameter logic [IRQ_W-1:0] RSVD_MASK = 16'h2105,
  localparam int              NSRC      = NUM_PCI + 2,
  localparam int              AW        = $clog2(NSRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  input  logic [NUM_PCI-1:0] pci_int_ni,
  input  logic               mb_int_ni,
  input  logic [1:0]         ide_int_i,
  output logic [IRQ_W-1:0]   irq_o
);
  localparam int MB_IDX  = NUM_PCI;
  localparam int IDE_IDX = NUM_PCI + 1;

  route_t [NSRC-1:0]          route_q;
  logic   [NSRC-1:0]          src_en;
  logic   [NSRC-1:0]          src_req;
  logic   [NSRC-1:0][IRQ_W-1:0] src_vec;
  logic                       unused_rt_bits;

  irq_route_regs #(.NSRC(NSRC), .AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .route_o (route_q)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i < NUM_PCI) begin : g_pci
      assign src_en[i]  = !route_q[i][CTL_BIT];
      assign src_req[i] = !pci_int_ni[i];
    end else if (i == MB_IDX) begin : g_mb
      assign src_en[i]  = !route_q[i][CTL_BIT];
      assign src_req[i] = !mb_int_ni;
    end else begin : g_ide
      // IDE control bit is an enable, not a disable
      assign src_en[i]  = route_q[i][CTL_BIT];
      assign src_req[i] = |ide_int_i;
    end

    irq_route_dec #(.RSVD_MASK(RSVD_MASK)) u_dec (
      .en_i  (src_en[i]),
      .req_i (src_req[i]),
      .num_i (route_q[i][NUM_W-1:0]),
      .vec_o (src_vec[i])
    );
  end

  irq_merge #(.NSRC(NSRC)) u_merge (
    .vec_i (src_vec),
    .irq_o (irq_o)
  );

  always_comb begin
    unused_rt_bits = 1'b0;
    for (int i = 0; i < NSRC; i++)
      unused_rt_bits = unused_rt_bits ^ (^route_q[i][CTL_BIT-1:NUM_W]);
  end
endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk
  import irq_steer_pkg::*;
#(
  parameter int               NUM_PCI   = 4,
  parameter logic [IRQ_W-1:0] RSVD_MASK = 16'h2105,
  localparam int              NSRC      = NUM_PCI + 2,
  localparam int              AW        = $clog2(NSRC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [AW-1:0]      addr_i,
  input logic [7:0]         wdata_i,
  input logic [7:0]         rdata_o,
  input logic [NUM_PCI-1:0] pci_int_ni,
  input logic               mb_int_ni,
  input logic [1:0]         ide_int_i,
  input logic [IRQ_W-1:0]   irq_o,
  input route_t [NSRC-1:0]  route_i
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live_q |-> (irq_o == '0));

  p_readback_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(wr_en_i) && ($past(addr_i) == addr_i) && (int'(addr_i) < NSRC))
    |-> (rdata_o == ($past(wdata_i) & RT_MASK)));

  p_zero_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~RT_MASK) == 8'h00);

  for (genvar i = 0; i < NUM_PCI; i++) begin : g_pci
    p_pci_route_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!route_i[i][CTL_BIT] && !pci_int_ni[i] && !RSVD_MASK[route_i[i][NUM_W-1:0]])
      |-> irq_o[route_i[i][NUM_W-1:0]]);
  end

  p_mb_route_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!route_i[NUM_PCI][CTL_BIT] && !mb_int_ni && !RSVD_MASK[route_i[NUM_PCI][NUM_W-1:0]])
    |-> irq_o[route_i[NUM_PCI][NUM_W-1:0]]);

  p_ide_route_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_i[NUM_PCI+1][CTL_BIT] && (|ide_int_i) && !RSVD_MASK[route_i[NUM_PCI+1][NUM_W-1:0]])
    |-> irq_o[route_i[NUM_PCI+1][NUM_W-1:0]]);

  p_reserved_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & RSVD_MASK) == '0);

  p_unmapped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(addr_i) >= NSRC) |-> (rdata_o == 8'h00));
endmodule

bind irq_steer_top irq_steer_chk #(.NUM_PCI(NUM_PCI), .RSVD_MASK(RSVD_MASK)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .pci_int_ni (pci_int_ni),
  .mb_int_ni  (mb_int_ni),
  .ide_int_i  (ide_int_i),
  .irq_o      (irq_o),
  .route_i    (route_q)
);

// File: tb/irq_steer_top_test.sv
module irq_steer_top_test;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [3:0]  pci_int_ni = 4'hF;
  logic        mb_int_ni = 1'b1;
  logic [1:0]  ide_int_i = 2'b00;
  logic [15:0] irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  irq_steer_top uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pci_int_ni(pci_int_ni),
    .mb_int_ni(mb_int_ni), .ide_int_i(ide_int_i), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    #1 wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    addr_i = a;
    #1 chk(req, {8'h00, rdata_o}, {8'h00, exp});
  endtask

  task automatic irq_chk(input string req, input logic [15:0] exp);
    #1 chk(req, irq_o, exp);
  endtask

  task automatic quiet_all();
    pci_int_ni = 4'hF; mb_int_ni = 1'b1; ide_int_i = 2'b00;
    for (int i = 0; i < 5; i++) wr(3'(i), 8'h80);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 6; i++) rd_chk("R1 reset value", 3'(i), 8'h80);
    pci_int_ni = 4'h0; mb_int_ni = 1'b0; ide_int_i = 2'b11;
    irq_chk("R1 all sources active after reset", 16'h0000);
    pci_int_ni = 4'hF; mb_int_ni = 1'b1; ide_int_i = 2'b00;
  endtask

  task automatic t_mask();
    wr(3'd0, 8'hFF);
    rd_chk("R2 mask FF", 3'd0, 8'h8F);
    wr(3'd5, 8'h75);
    rd_chk("R2 mask 75", 3'd5, 8'h05);
    wr(3'd2, 8'h3A);
    rd_chk("R2 mask 3A", 3'd2, 8'h0A);
    quiet_all();
  endtask

  task automatic t_pci();
    wr(3'd1, 8'h0B);
    pci_int_ni = 4'b1101;
    irq_chk("R3 INTB to 11", 16'h0800);
    pci_int_ni = 4'b1111;
    irq_chk("R3 INTB idle", 16'h0000);
    wr(3'd3, 8'h07);
    pci_int_ni = 4'b0111;
    irq_chk("R3 INTD to 7", 16'h0080);
    wr(3'd1, 8'h8B);
    pci_int_ni = 4'b0101;
    irq_chk("R3 INTB disabled", 16'h0080);
    quiet_all();
  endtask

  task automatic t_mb();
    wr(3'd4, 8'h05);
    mb_int_ni = 1'b0;
    irq_chk("R4 mb to 5", 16'h0020);
    wr(3'd4, 8'h85);
    irq_chk("R4 mb disabled", 16'h0000);
    quiet_all();
  endtask

  task automatic t_ide();
    wr(3'd5, 8'h8E);
    ide_int_i = 2'b01;
    irq_chk("R5 ide ch0", 16'h4000);
    ide_int_i = 2'b10;
    irq_chk("R5 ide ch1", 16'h4000);
    ide_int_i = 2'b00;
    irq_chk("R5 ide idle", 16'h0000);
    wr(3'd5, 8'h0E);
    ide_int_i = 2'b11;
    irq_chk("R5 ide bit7 clear", 16'h0000);
    quiet_all();
  endtask

  task automatic t_rsvd();
    logic [7:0] nums [4] = '{8'd0, 8'd2, 8'd8, 8'd13};
    pci_int_ni = 4'b1110;
    for (int i = 0; i < 4; i++) begin
      wr(3'd0, nums[i]);
      irq_chk("R6 reserved target", 16'h0000);
    end
    wr(3'd5, 8'h88);
    ide_int_i = 2'b11;
    irq_chk("R6 ide to reserved 8", 16'h0000);
    quiet_all();
  endtask

  task automatic t_or();
    wr(3'd0, 8'h0A);
    wr(3'd2, 8'h0A);
    wr(3'd4, 8'h03);
    pci_int_ni = 4'b1110;
    irq_chk("R7 A only", 16'h0400);
    pci_int_ni = 4'b1010;
    irq_chk("R7 A and C", 16'h0400);
    pci_int_ni = 4'b1011;
    irq_chk("R7 C only", 16'h0400);
    mb_int_ni = 1'b0;
    irq_chk("R7 C and mb", 16'h0408);
    quiet_all();
  endtask

  task automatic t_timing();
    wr(3'd3, 8'h09);
    @(negedge clk_i);
    pci_int_ni = 4'b0111;
    irq_chk("R8 same-cycle assert", 16'h0200);
    pci_int_ni = 4'b1111;
    irq_chk("R8 same-cycle release", 16'h0000);
    pci_int_ni = 4'b0111;
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 3'd3; wdata_i = 8'h0C;
    #1 chk("R8 old route before edge", irq_o, 16'h0200);
    @(posedge clk_i);
    #1 wr_en_i = 1'b0;
    chk("R8 new route after edge", irq_o, 16'h1000);
    quiet_all();
  endtask

  task automatic t_unmapped();
    wr(3'd1, 8'h06);
    pci_int_ni = 4'b1101;
    wr(3'd6, 8'hFF);
    wr(3'd7, 8'h8F);
    rd_chk("R9 read addr6", 3'd6, 8'h00);
    rd_chk("R9 read addr7", 3'd7, 8'h00);
    rd_chk("R9 INTB kept", 3'd1, 8'h06);
    rd_chk("R9 INTA kept", 3'd0, 8'h80);
    rd_chk("R9 ide kept", 3'd5, 8'h00);
    irq_chk("R9 output kept", 16'h0040);
    quiet_all();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 2 + 3);
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    t_reset();
    t_mask();
    t_pci();
    t_mb();
    t_ide();
    t_rsvd();
    t_or();
    t_timing();
    t_unmapped();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule